// File: doc/BRIEF.md
# Minimal Fetch-Decode-Execute Processor Core

A small clocked processor that runs 8-bit instructions out of a 16-word by 8-bit memory. This memory holds both the program and its data. The core has four general registers, a program counter, an instruction register, a temporary ALU result register and a three-bit flag register. Every instruction passes through fetch, decode and execute steps, and each clock edge performs one of those steps. Arithmetic and logic results go into the temporary register first and are then written into register 0. The flags can steer conditional jumps. A HALT word stops the core, so data words that follow the program are never run.

A test environment or a boot controller fills the memory through a load port while reset is held high. It then releases reset and waits for the halted output. A separate registered peek port reads any memory word at any time, so results that a program stores can be checked at the ports.

Instruction word: bits [7:6] hold the class. 00 is ALU, 01 is LOAD, 10 is STORE and 11 is control. For LOAD and STORE, bits [5:4] name the register and bits [3:0] the memory address. For ALU, bits [5:3] hold the operation and bits [2:1] the second operand register. Register 0 is always the first operand and also the destination. For control, bits [5:4] hold the condition and bits [3:0] the target address. The word 0xFF is HALT.

Top module: `fde_core`

## Requirements
- R1: While reset is high and for the first cycle after it falls, pc_o is 0, halted_o is 0 and flags_o is 0. The first fetch after reset reads address 0.
- R2: LOAD (01 rr aaaa) copies memory word aaaa into register rr. STORE (10 rr aaaa) writes register rr into memory word aaaa.
- R3: ALU (00 ooo ss x) computes r0 op rs and commits the result into register 0. The op codes are 0 OR, 1 NAND, 2 NOR, 3 AND, 4 ADD, 5 SUB (r0 minus rs), 6 XOR, 7 pass rs.
- R4: An ALU instruction sets the flags as follows. flags_o[1] (zero) is set when the result is 0. flags_o[0] (negative) copies result bit 7. flags_o[2] (overflow) marks two's-complement overflow for ADD and SUB and is 0 for every other operation.
- R5: LOAD, STORE, jump and HALT instructions leave the flags unchanged.
- R6: Every instruction other than HALT takes exactly 4 cycles. Every non-control instruction advances the program counter by 1, wrapping at 16. HALT raises halted_o on the 3rd cycle of its fetch.
- R7: Control word 11 00 tttt always jumps: pc becomes tttt.
- R8: Control word 11 01 tttt jumps when zero is set, and 11 10 tttt jumps when negative is set. Otherwise the pc advances by 1.
- R9: Control word 11 11 tttt (tttt not 1111) jumps only when zero and negative are both clear. Otherwise the pc advances by 1.
- R10: Once halted, halted_o stays high and pc_o holds until reset, and the core writes no more memory words.
- R11: ld_en writes ld_data to word ld_addr only while rst is high; it is ignored otherwise. peek_data returns the word at peek_addr one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; memory loading is allowed while high |
| ld_en | input | 1 | Memory load strobe (honoured only in reset) |
| ld_addr | input | 4 | Memory load address |
| ld_data | input | 8 | Memory load word |
| peek_addr | input | 4 | Memory observation address |
| peek_data | output | 8 | Word at peek_addr, one cycle late |
| pc_o | output | 4 | Program counter |
| flags_o | output | 3 | {overflow, zero, negative} |
| halted_o | output | 1 | High once HALT has executed |

## Verification
On every cycle the assertions check several properties. Halt is sticky and freezes both the program counter and memory writes. Flags move only after an ALU execute step. The program counter steps by one after non-control instructions and takes the target on an unconditional jump. The bench scenarios are the only way to show the other behaviours: the values each ALU operation and flag combination produce, whether each conditional jump is taken or falls through, the exact cycle count until halt, and that the load port and data words past HALT have no effect.

// File: rtl/fde_pkg.sv
package fde_pkg;
  typedef enum logic [1:0] {CL_ALU = 2'b00, CL_LOAD = 2'b01, CL_STORE = 2'b10, CL_CTRL = 2'b11} iclass_e;
  typedef enum logic [2:0] {
    OP_OR = 3'd0, OP_NAND = 3'd1, OP_NOR = 3'd2, OP_AND = 3'd3,
    OP_ADD = 3'd4, OP_SUB = 3'd5, OP_XOR = 3'd6, OP_PASS = 3'd7
  } aluop_e;
  typedef enum logic [1:0] {CND_ALWAYS = 2'b00, CND_ZERO = 2'b01, CND_NEG = 2'b10, CND_ABOVE = 2'b11} cond_e;
  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_COMMIT, ST_HALT} state_e;
  typedef struct packed {
    logic ovf;
    logic zero;
    logic neg;
  } flags_t;
  localparam logic [7:0] HALT_WORD = 8'hFF;
endpackage

// File: rtl/fde_alu.sv
module fde_alu
  import fde_pkg::*;
#(
  parameter int DW = 8
) (
  input  aluop_e        op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output flags_t        fl
);
  localparam int MSB = DW - 1;

  always_comb begin
    fl.ovf = 1'b0;
    unique case (op)
      OP_OR:   y = a | b;
      OP_NAND: y = ~(a & b);
      OP_NOR:  y = ~(a | b);
      OP_AND:  y = a & b;
      OP_ADD: begin
        y = a + b;
        fl.ovf = (a[MSB] == b[MSB]) && (y[MSB] != a[MSB]);
      end
      OP_SUB: begin
        y = a - b;
        fl.ovf = (a[MSB] != b[MSB]) && (y[MSB] != a[MSB]);
      end
      OP_XOR:  y = a ^ b;
      default: y = b;
    endcase
    fl.zero = (y == '0);
    fl.neg  = y[MSB];
  end
endmodule

// File: rtl/fde_ram.sv
module fde_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/fde_regs.sv
module fde_regs #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [RW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (we && waddr == RW'(g)) regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/fde_core.sv
module fde_core
  import fde_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] peek_addr,
  output logic [DW-1:0] peek_data,
  output logic [AW-1:0] pc_o,
  output logic [2:0]    flags_o,
  output logic          halted_o
);
  localparam int RW = $clog2(NREG);
  typedef logic [AW-1:0] addr_t;

  state_e        state_q;
  addr_t         pc_q;
  logic [DW-1:0] ir_q, tmp_q;
  flags_t        flags_q;
  logic          halted_q;

  logic [DW-1:0] rdata, ra_val, rb_val, alu_y;
  flags_t        alu_fl;
  logic          core_we, ram_we, rf_we, take_jump;
  addr_t         core_addr, ram_addr;
  logic [DW-1:0] ram_wdata, rf_wdata;
  logic [RW-1:0] rf_waddr;

  iclass_e ir_class;
  cond_e   ir_cond;
  assign ir_class = iclass_e'(ir_q[7:6]);
  assign ir_cond  = cond_e'(ir_q[5:4]);

  // Memory port A: loader while in reset, core otherwise
  always_comb begin
    unique case (state_q)
      ST_FETCH:  core_addr = pc_q;
      ST_DECODE: core_addr = rdata[AW-1:0];
      default:   core_addr = ir_q[AW-1:0];
    endcase
  end
  assign core_we   = (state_q == ST_EXEC) && (ir_class == CL_STORE);
  assign ram_we    = rst ? ld_en : core_we;
  assign ram_addr  = rst ? ld_addr : core_addr;
  assign ram_wdata = rst ? ld_data : rb_val;

  fde_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .a_we(ram_we), .a_addr(ram_addr), .a_wdata(ram_wdata), .a_rdata(rdata),
    .b_addr(peek_addr), .b_rdata(peek_data)
  );

  // Register file: LOAD at execute, ALU commit into r0
  assign rf_we    = (state_q == ST_EXEC && ir_class == CL_LOAD) ||
                    (state_q == ST_COMMIT && ir_class == CL_ALU);
  assign rf_waddr = (ir_class == CL_LOAD) ? ir_q[5:4] : '0;
  assign rf_wdata = (ir_class == CL_LOAD) ? rdata : tmp_q;

  fde_regs #(.NREG(NREG), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a('0), .rdata_a(ra_val),
    .raddr_b((ir_class == CL_ALU) ? ir_q[2:1] : ir_q[5:4]), .rdata_b(rb_val)
  );

  fde_alu #(.DW(DW)) u_alu (
    .op(aluop_e'(ir_q[5:3])), .a(ra_val), .b(rb_val), .y(alu_y), .fl(alu_fl)
  );

  always_comb begin
    unique case (ir_cond)
      CND_ALWAYS: take_jump = 1'b1;
      CND_ZERO:   take_jump = flags_q.zero;
      CND_NEG:    take_jump = flags_q.neg;
      default:    take_jump = !flags_q.zero && !flags_q.neg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FETCH;
      pc_q     <= '0;
      ir_q     <= '0;
      tmp_q    <= '0;
      flags_q  <= '0;
      halted_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_FETCH:  state_q <= ST_DECODE;
        ST_DECODE: begin
          ir_q    <= rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (ir_q == HALT_WORD) begin
            state_q  <= ST_HALT;
            halted_q <= 1'b1;
          end else begin
            if (ir_class == CL_ALU) begin
              tmp_q   <= alu_y;
              flags_q <= alu_fl;
            end
            state_q <= ST_COMMIT;
          end
        end
        ST_COMMIT: begin
          pc_q    <= (ir_class == CL_CTRL && take_jump) ? ir_q[AW-1:0] : pc_q + 1'b1;
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign pc_o     = pc_q;
  assign flags_o  = flags_q;
  assign halted_o = halted_q;

  // Assertions
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o);
  p_halt_pc_r10: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> $stable(pc_o));
  p_halt_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> !core_we);
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(state_q == ST_EXEC && ir_class == CL_ALU) |=> $stable(flags_o));
  p_pc_step_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COMMIT && ir_class != CL_CTRL) |=> pc_o == addr_t'($past(pc_o) + 1'b1));
  p_jump_always_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COMMIT && ir_class == CL_CTRL && ir_cond == CND_ALWAYS)
      |=> pc_o == $past(ir_q[AW-1:0]));
endmodule

// File: tb/fde_core_bench.sv
module fde_core_bench;
  typedef struct packed {
    logic [2:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic [2:0] fl;
  } vec_t;

  // flags field is {overflow, zero, negative}
  localparam vec_t VEC [12] = '{
    '{3'd4, 8'h05, 8'h03, 8'h08, 3'b000},
    '{3'd4, 8'h7F, 8'h01, 8'h80, 3'b101},
    '{3'd4, 8'hFF, 8'h01, 8'h00, 3'b010},
    '{3'd5, 8'h05, 8'h05, 8'h00, 3'b010},
    '{3'd5, 8'h03, 8'h05, 8'hFE, 3'b001},
    '{3'd5, 8'h80, 8'h01, 8'h7F, 3'b100},
    '{3'd0, 8'hF0, 8'h0F, 8'hFF, 3'b001},
    '{3'd1, 8'hFF, 8'hFF, 8'h00, 3'b010},
    '{3'd2, 8'h01, 8'h02, 8'hFC, 3'b001},
    '{3'd3, 8'hAA, 8'h0F, 8'h0A, 3'b000},
    '{3'd6, 8'h5A, 8'h5A, 8'h00, 3'b010},
    '{3'd7, 8'h12, 8'h33, 8'h33, 3'b000}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [3:0] peek_addr = '0;
  logic [7:0] peek_data;
  logic [3:0] pc_o;
  logic [2:0] flags_o;
  logic       halted_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc;
  logic [7:0] img [16];
  logic [7:0] pk;

  always #5ns clk = ~clk;

  fde_core u_fde_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .peek_addr(peek_addr), .peek_data(peek_data), .pc_o(pc_o),
    .flags_o(flags_o), .halted_o(halted_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
  endtask

  // Load image under reset, release, count cycles until halted
  task automatic run_prog();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      ld_en = 1'b1; ld_addr = 4'(i); ld_data = img[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted_o && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic peek(input logic [3:0] a);
    peek_addr = a;
    @(negedge clk);
    @(negedge clk);
    pk = peek_data;
  endtask

  initial begin
    #1ms;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    clear_img();
    img[0] = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    chk("R1 pc in reset", pc_o, 0);
    chk("R1 halted in reset", halted_o, 0);
    chk("R1 flags in reset", flags_o, 0);

    // R2 R3 R4 R6: ALU vector table
    for (int v = 0; v < 12; v++) begin
      clear_img();
      img[0] = 8'h4E;                           // LOAD r0,14
      img[1] = 8'h5F;                           // LOAD r1,15
      img[2] = {2'b00, VEC[v].op, 2'b01, 1'b0}; // ALU op with r1
      img[3] = 8'h8D;                           // STORE r0,13
      img[4] = 8'hFF;
      img[14] = VEC[v].a;
      img[15] = VEC[v].b;
      run_prog();
      chk($sformatf("R6 halt cycles vec%0d", v), cyc, 19);
      chk($sformatf("R6 pc at halt vec%0d", v), pc_o, 4);
      chk($sformatf("R4 flags vec%0d", v), flags_o, VEC[v].fl);
      peek(4'd13);
      chk($sformatf("R3 R2 result vec%0d", v), pk, VEC[v].res);
    end

    // R7 R8 R9: jumps; taken path stores b at 11, fall-through stores b at 12
    for (int j = 0; j < 8; j++) begin
      logic [7:0] jw, a, b;
      logic tk;
      string tg;
      case (j)
        0: begin jw = 8'hC6; a = 8'h05; b = 8'h03; tk = 1; tg = "R7 always"; end
        1: begin jw = 8'hD6; a = 8'h05; b = 8'h05; tk = 1; tg = "R8 zero taken"; end
        2: begin jw = 8'hD6; a = 8'h05; b = 8'h03; tk = 0; tg = "R8 zero fall"; end
        3: begin jw = 8'hE6; a = 8'h03; b = 8'h05; tk = 1; tg = "R8 neg taken"; end
        4: begin jw = 8'hE6; a = 8'h05; b = 8'h03; tk = 0; tg = "R8 neg fall"; end
        5: begin jw = 8'hF6; a = 8'h05; b = 8'h03; tk = 1; tg = "R9 above taken"; end
        6: begin jw = 8'hF6; a = 8'h05; b = 8'h05; tk = 0; tg = "R9 above zero fall"; end
        default: begin jw = 8'hF6; a = 8'h03; b = 8'h05; tk = 0; tg = "R9 above neg fall"; end
      endcase
      clear_img();
      img[0] = 8'h4E; img[1] = 8'h5F; img[2] = 8'h2A; img[3] = jw;
      img[4] = 8'h9C; img[5] = 8'hFF; img[6] = 8'h9B; img[7] = 8'hFF;
      img[14] = a; img[15] = b;
      run_prog();
      chk({tg, " pc"}, pc_o, tk ? 7 : 5);
      peek(4'd11);
      chk({tg, " taken word"}, pk, tk ? b : 8'h00);
      peek(4'd12);
      chk({tg, " fall word"}, pk, tk ? 8'h00 : b);
    end

    // R5: flags hold across LOAD and STORE
    clear_img();
    img[0] = 8'h4E; img[1] = 8'h5F; img[2] = 8'h2A;  // SUB gives zero
    img[3] = 8'h4D; img[4] = 8'h8C; img[5] = 8'hFF;  // LOAD r0,13 ; STORE r0,12
    img[13] = 8'h81; img[14] = 8'h09; img[15] = 8'h09;
    run_prog();
    chk("R5 flags held after LOAD/STORE", flags_o, 3'b010);
    peek(4'd12);
    chk("R5 R2 reloaded r0 stored", pk, 8'h81);

    // R10: halt freezes; data word after HALT never runs
    clear_img();
    img[0] = 8'h4E; img[1] = 8'hFF; img[2] = 8'h8C; img[14] = 8'h77;
    run_prog();
    chk("R10 pc at halt", pc_o, 1);
    repeat (20) @(negedge clk);
    chk("R10 halted sticky", halted_o, 1);
    chk("R10 pc held", pc_o, 1);
    peek(4'd12);
    chk("R10 data word not executed", pk, 8'h00);

    // R11: load port ignored outside reset
    ld_en = 1'b1; ld_addr = 4'd14; ld_data = 8'hEE;
    @(negedge clk);
    ld_en = 1'b0;
    peek(4'd14);
    chk("R11 load ignored out of reset", pk, 8'h77);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule